// File: doc/BRIEF.md
# Regulator Fault Protection Sequencer

This block is the control state machine that decides whether the switching drivers of a buck regulator may run. It takes digital fault flags from the analog comparators: a hard overcurrent flag, a low and a high over-voltage flag, an over-voltage release flag and a pair of over-temperature trip/clear flags. It also takes a one-cycle pulse from an external soft-start timer marking the end of each soft-start period. From these it drives a single enable for both the high-side and low-side drivers and a request that tells the soft-start ramp generator to run.

After enable the sequencer starts a soft-start and moves to normal regulation once the first period pulse arrives. A hard overcurrent lets the drivers run for two more cycles and then enters hiccup. In hiccup the drivers stay off while five period pulses are counted, and then a real soft-start is requested. Over-voltage holds the drivers off until the release flag is seen. Over-temperature holds them off until the clear flag is seen. Over-temperature outranks over-voltage, and over-voltage outranks hiccup. The state and a hiccup indicator are brought out so that every transition can be observed.

Top module: `reg_fault_seq`

## Requirements
- R1: A synchronous `rst`, `por` high or `en` low sends the block to IDLE (code 0) at the next clock edge, with `drv_en`, `ss_req` and `hiccup_on` low. Flags seen in IDLE while `en` is low have no effect.
- R2: From IDLE with `en` high, the next edge enters SOFT (code 1) with `drv_en`=1 and `ss_req`=1. An `ss_tick` pulse in SOFT moves to RUN (code 2) with `drv_en`=1 and `ss_req`=0.
- R3: `oc_hard` sampled in SOFT or RUN enters OC_WAIT (code 3) with the drivers still on. Exactly `OC_DELAY` (default 2) edges after the flag is sampled, the block enters HICCUP (code 4) with `drv_en`=0 and `hiccup_on`=1.
- R4: In HICCUP, `drv_en` and `ss_req` stay low until the `DUMMY_PERIODS`-th (default 5) `ss_tick` pulse. The edge that samples that pulse enters SOFT with `ss_req`=1 and `hiccup_on`=0.
- R5: `ov_soft` (the lower over-voltage flag) is ignored in SOFT and HICCUP. In RUN or OC_WAIT it sends the block to OVP (code 5) with `drv_en`=0.
- R6: `ov_hard` (the higher over-voltage flag) sends the block to OVP from SOFT, RUN, OC_WAIT or HICCUP at the next edge, with `drv_en`=0.
- R7: OVP is held while `ov_release` is low. When it is high, the block returns to RUN if a soft-start had finished since the last IDLE, HICCUP or OTP, and to SOFT otherwise.
- R8: `ot_hot` sends the block to OTP (code 6) from any non-IDLE state, with `drv_en`=0. OTP is left only when `ot_cool` is high and `ot_hot` is low, and the block then goes to SOFT.
- R9: Priority is over-temperature, then over-voltage, then overcurrent and hiccup. A release flag, the final hiccup pulse or an overcurrent arriving together with a higher-priority fault does not turn the drivers on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| por | input | 1 | Supply below power-on threshold, active high |
| oc_hard | input | 1 | Second-level overcurrent flag |
| ov_soft | input | 1 | Lower over-voltage flag, masked during soft-start |
| ov_hard | input | 1 | Higher over-voltage flag, always active |
| ov_release | input | 1 | Feedback at or below the over-voltage release level |
| ot_hot | input | 1 | Junction over-temperature trip |
| ot_cool | input | 1 | Junction back below the restart temperature |
| ss_tick | input | 1 | One-cycle pulse at the end of each soft-start period |
| drv_en | output | 1 | Enable for both high-side and low-side drivers |
| ss_req | output | 1 | Request to run a real soft-start ramp |
| fsm_state | output | 3 | Current state code |
| hiccup_on | output | 1 | Hiccup retry in progress |

## Verification
The most delicate overlap is the fifth dummy period pulse arriving in the same cycle as the high over-voltage flag. The bench drives both in one cycle and requires OVP with the drivers off, not SOFT. It likewise presents the over-voltage release together with an over-temperature trip, and the temperature clear together with a still-active trip. In both cases the bench expects the higher-priority fault state. Each outcome is judged from `fsm_state`, `drv_en` and `ss_req` one edge after the combined stimulus.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SOFT = 3'd1,
    ST_RUN  = 3'd2,
    ST_OCW  = 3'd3,
    ST_HIC  = 3'd4,
    ST_OVP  = 3'd5,
    ST_OTP  = 3'd6
  } rfs_state_e;
endpackage

// File: rtl/rfs_evt_counter.sv
module rfs_evt_counter #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/rfs_ov_guard.sv
module rfs_ov_guard (
  input  logic armed,
  input  logic ov_soft,
  input  logic ov_hard,
  output logic trip
);
  // The lower threshold counts only once a soft-start has completed.
  always_comb begin
    trip = ov_hard;
    if (armed && ov_soft) begin
      trip = 1'b1;
    end
  end
endmodule

// File: rtl/reg_fault_seq.sv
module reg_fault_seq #(
  parameter int OC_DELAY      = 2,
  parameter int DUMMY_PERIODS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       por,
  input  logic       oc_hard,
  input  logic       ov_soft,
  input  logic       ov_hard,
  input  logic       ov_release,
  input  logic       ot_hot,
  input  logic       ot_cool,
  input  logic       ss_tick,
  output logic       drv_en,
  output logic       ss_req,
  output logic [2:0] fsm_state,
  output logic       hiccup_on
);
  import rfs_pkg::*;

  rfs_state_e state_q, state_d;
  logic       ss_done_q;
  logic       ov_trip;
  logic       oc_hit, hic_hit;
  logic       go_off;

  assign go_off = !en || por;

  rfs_ov_guard u_ov_guard (
    .armed   ((state_q == ST_RUN) || (state_q == ST_OCW)),
    .ov_soft (ov_soft),
    .ov_hard (ov_hard),
    .trip    (ov_trip)
  );

  rfs_evt_counter #(.LIMIT(OC_DELAY)) u_oc_delay (
    .clk (clk),
    .rst (rst),
    .clr (state_q != ST_OCW),
    .inc (state_q == ST_OCW),
    .hit (oc_hit)
  );

  rfs_evt_counter #(.LIMIT(DUMMY_PERIODS)) u_dummy_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state_q != ST_HIC),
    .inc ((state_q == ST_HIC) && ss_tick),
    .hit (hic_hit)
  );

  always_comb begin
    state_d = state_q;
    if (go_off) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_SOFT;
        ST_OTP: begin
          if (ot_cool && !ot_hot) state_d = ST_SOFT;
        end
        default: begin
          if (ot_hot) begin
            state_d = ST_OTP;
          end else if (state_q == ST_OVP) begin
            if (ov_release && !ov_hard) state_d = ss_done_q ? ST_RUN : ST_SOFT;
          end else if (ov_trip) begin
            state_d = ST_OVP;
          end else begin
            case (state_q)
              ST_SOFT: begin
                if (oc_hard)      state_d = ST_OCW;
                else if (ss_tick) state_d = ST_RUN;
              end
              ST_RUN:  if (oc_hard) state_d = ST_OCW;
              ST_OCW:  if (oc_hit)  state_d = ST_HIC;
              ST_HIC:  if (hic_hit) state_d = ST_SOFT;
              default: state_d = ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ss_done_q <= 1'b0;
      drv_en    <= 1'b0;
      ss_req    <= 1'b0;
      hiccup_on <= 1'b0;
    end else begin
      state_q   <= state_d;
      drv_en    <= (state_d == ST_SOFT) || (state_d == ST_RUN) || (state_d == ST_OCW);
      ss_req    <= (state_d == ST_SOFT);
      hiccup_on <= (state_d == ST_HIC);
      if ((state_d == ST_IDLE) || (state_d == ST_HIC) || (state_d == ST_OTP)) begin
        ss_done_q <= 1'b0;
      end else if ((state_q == ST_SOFT) && (state_d == ST_RUN)) begin
        ss_done_q <= 1'b1;
      end
    end
  end

  assign fsm_state = state_q;

  AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    go_off |=> (fsm_state == 3'd0) && !drv_en && !ss_req); // R1

  AST_HIC_FROM_OCW: assert property (@(posedge clk) disable iff (rst)
    $rose(hiccup_on) |-> ($past(state_q) == ST_OCW)); // R3

  AST_SOFT_MASK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SOFT && ov_soft && !ov_hard && !ot_hot && !oc_hard && !ss_tick && !go_off)
    |=> (state_q == ST_SOFT)); // R5

  AST_OVP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OVP && !ov_release && !ot_hot && !go_off) |=> (state_q == ST_OVP) && !drv_en); // R7

  AST_OT_WINS: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && ot_hot && !go_off) |=> (state_q == ST_OTP) && !drv_en); // R9
endmodule

// File: tb/test_reg_fault_seq.sv
module test_reg_fault_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, por = 1'b0, oc_hard = 1'b0, ov_soft = 1'b0, ov_hard = 1'b0;
  logic ov_release = 1'b0, ot_hot = 1'b0, ot_cool = 1'b0, ss_tick = 1'b0;
  logic       drv_en, ss_req, hiccup_on;
  logic [2:0] fsm_state;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reg_fault_seq i_reg_fault_seq (
    .clk(clk), .rst(rst), .en(en), .por(por), .oc_hard(oc_hard),
    .ov_soft(ov_soft), .ov_hard(ov_hard), .ov_release(ov_release),
    .ot_hot(ot_hot), .ot_cool(ot_cool), .ss_tick(ss_tick),
    .drv_en(drv_en), .ss_req(ss_req), .fsm_state(fsm_state), .hiccup_on(hiccup_on)
  );

  // inputs {en,por,oc_hard,ov_soft,ov_hard,ov_release,ot_hot,ot_cool,ss_tick}
  // expected {state, drv_en, ss_req, hiccup_on}, then requirement number
  localparam int NV = 28;
  localparam logic [18:0] VEC [NV] = '{
    {9'b100000000, 3'd1, 3'b110, 4'd2},  // R2 enable -> SOFT
    {9'b100100000, 3'd1, 3'b110, 4'd5},  // R5 low OV masked in SOFT
    {9'b100000001, 3'd2, 3'b100, 4'd2},  // R2 period pulse -> RUN
    {9'b101000000, 3'd3, 3'b100, 4'd3},  // R3 hard OC -> OC_WAIT
    {9'b100000000, 3'd3, 3'b100, 4'd3},  // R3 still driving
    {9'b100000000, 3'd4, 3'b001, 4'd3},  // R3 off after two edges
    {9'b100100000, 3'd4, 3'b001, 4'd5},  // R5 low OV masked in HICCUP
    {9'b100000001, 3'd4, 3'b001, 4'd4},  // R4 dummy 1
    {9'b100000001, 3'd4, 3'b001, 4'd4},  // R4 dummy 2
    {9'b100000001, 3'd4, 3'b001, 4'd4},  // R4 dummy 3
    {9'b100000001, 3'd4, 3'b001, 4'd4},  // R4 dummy 4
    {9'b100000001, 3'd1, 3'b110, 4'd4},  // R4 dummy 5 -> real soft-start
    {9'b100000001, 3'd2, 3'b100, 4'd2},  // R2 -> RUN
    {9'b100100000, 3'd5, 3'b000, 4'd5},  // R5 low OV acts in RUN
    {9'b100000000, 3'd5, 3'b000, 4'd7},  // R7 held without release
    {9'b100001000, 3'd2, 3'b100, 4'd7},  // R7 release -> RUN
    {9'b100010100, 3'd6, 3'b000, 4'd9},  // R9 OT beats OV
    {9'b100001000, 3'd6, 3'b000, 4'd8},  // R8 OV release no effect in OTP
    {9'b100000010, 3'd1, 3'b110, 4'd8},  // R8 cool -> SOFT
    {9'b100010000, 3'd5, 3'b000, 4'd6},  // R6 high OV in SOFT
    {9'b100001000, 3'd1, 3'b110, 4'd7},  // R7 release -> SOFT (not finished)
    {9'b101010000, 3'd5, 3'b000, 4'd9},  // R9 OV beats OC
    {9'b100001100, 3'd6, 3'b000, 4'd9},  // R9 release with OT -> OTP
    {9'b100000010, 3'd1, 3'b110, 4'd8},  // R8
    {9'b100000001, 3'd2, 3'b100, 4'd2},  // R2
    {9'b110000000, 3'd0, 3'b000, 4'd1},  // R1 POR -> IDLE
    {9'b100000000, 3'd1, 3'b110, 4'd2},  // R2 re-enable
    {9'b000000000, 3'd0, 3'b000, 4'd1}   // R1 enable low -> IDLE
  };

  task automatic step(input logic r, input logic [8:0] ins, input logic [5:0] exp, input int req);
    logic [5:0] act;
    rst = r;
    {en, por, oc_hard, ov_soft, ov_hard, ov_release, ot_hot, ot_cool, ss_tick} = ins;
    @(posedge clk);
    #1;
    act = {fsm_state, drv_en, ss_req, hiccup_on};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(1'b1, 9'b100000000, {3'd0, 3'b000}, 1);        // R1 reset state
    step(1'b1, 9'b100000000, {3'd0, 3'b000}, 1);        // R1 held in reset
    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][18:10], VEC[i][9:4], int'(VEC[i][3:0]));
    end
    // R1 flags with enable low have no effect
    step(1'b0, 9'b001010001, {3'd0, 3'b000}, 1);
    // R9 final dummy pulse together with high OV
    step(1'b0, 9'b100000000, {3'd1, 3'b110}, 2);
    step(1'b0, 9'b100000001, {3'd2, 3'b100}, 2);
    step(1'b0, 9'b101000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b100000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b100000000, {3'd4, 3'b001}, 3);
    for (int k = 0; k < 4; k++) step(1'b0, 9'b100000001, {3'd4, 3'b001}, 4);
    step(1'b0, 9'b100010001, {3'd5, 3'b000}, 9);        // R9
    step(1'b0, 9'b100001000, {3'd1, 3'b110}, 7);        // R7 hiccup cleared completion
    // R8 OT during OC_WAIT
    step(1'b0, 9'b101000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b100000100, {3'd6, 3'b000}, 8);        // R8
    step(1'b0, 9'b100000110, {3'd6, 3'b000}, 9);        // R9 cool while still hot
    step(1'b0, 9'b100000010, {3'd1, 3'b110}, 8);
    // R6 high OV in HICCUP
    step(1'b0, 9'b101000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b100000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b100000000, {3'd4, 3'b001}, 3);
    step(1'b0, 9'b100010000, {3'd5, 3'b000}, 6);        // R6
    step(1'b0, 9'b100001000, {3'd1, 3'b110}, 7);
    // R1 enable low during OC_WAIT, then sync reset in SOFT
    step(1'b0, 9'b101000000, {3'd3, 3'b100}, 3);
    step(1'b0, 9'b000000000, {3'd0, 3'b000}, 1);
    step(1'b0, 9'b100000000, {3'd1, 3'b110}, 2);
    step(1'b1, 9'b100000000, {3'd0, 3'b000}, 1);        // R1
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule